// File: doc/BRIEF.md
# Programmable Tap-Select Timer Divider

A 16-bit binary counter, clocked from an external source, feeds an output stage that picks one of four counter bits as its source. With `free_run` high the block is a frequency divider: the output is a square wave whose period is 2^N input clocks, where N is the stage that is selected. With `free_run` low it is a single-transition timer: the output rises once, 2^(N-1) counts after a reset has been released, and then holds.

Reset can come from a master reset pin or from a power-on pulse. The power-on pulse starts when `pwr_ok` rises and lasts `POR_CYC` clocks. `por_skip` blocks this pulse, and the counter then stays idle until a master reset pulse has come and gone. While either reset is active, counting is stopped. `inv_out` selects whether the output pin carries the true level or its complement.

Top module: `tap_timer`

## Requirements
- R1: While running and out of reset, the counter advances by exactly one on each rising clock edge and wraps from 65535 to 0.
- R2: `stage_sel` picks the output stage as follows: 2'b00 → stage 13, 2'b01 → stage 10, 2'b10 → stage 8, 2'b11 → stage 16. Stage N is counter bit N-1.
- R3: With `free_run`=1, the true output equals the selected stage. It is low for 2^(N-1) counts after reset release, then high for 2^(N-1) counts, and repeats with period 2^N.
- R4: With `free_run`=0, the true output goes high at count 2^(N-1) after reset release. It stays high after the stage bit falls again, including across a counter wrap.
- R5: Driving `free_run` to 1 makes the output follow the selected stage at once, and the held level of R4 is dropped.
- R6: `tout` equals the true output when `inv_out`=0 and its complement when `inv_out`=1.
- R7: While `mrst`=1, the counter is held at zero and the held level is cleared. Counting restarts on the first edge after `mrst` returns to 0.
- R8: If `por_skip`=0 when `pwr_ok` rises, a reset of `POR_CYC` clocks is applied. The count is then k-(POR_CYC+1) after the k-th edge that follows the rise.
- R9: If `por_skip`=1 at power-up, the counter does not advance until a master reset pulse has been applied and released.
- R10: While `pwr_ok`=0, every stage is cleared and no counting takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| pwr_ok | input | 1 | Power-good; low clears all state asynchronously |
| mrst | input | 1 | Master reset, active high |
| por_skip | input | 1 | High suppresses the power-on reset pulse |
| stage_sel | input | 2 | Output stage select {B,A} |
| free_run | input | 1 | 1 = divider, 0 = single-transition timer |
| inv_out | input | 1 | 1 = drive the inverted output level |
| tout | output | 1 | Timer output |

## Verification
The assertions check on every cycle that the count advances by exactly one while running. They also check that it stays frozen while idle, that it is zero during a power-on reset and after any reset, and that the held timer level is never lost while timer mode continues. The bench covers what these cycle-local checks cannot reach. It runs a reference model under random changes of stage, mode, polarity and reset. It also runs directed scenarios: the exact edge on which the output rises after a power-on reset, the idle state when the power-on pulse is skipped, the tap mapping, and the held level surviving a 16-bit wrap.

// File: rtl/tap_timer.sv
module tap_timer #(
  parameter int CNT_W   = 16,
  parameter int STG_00  = 13,
  parameter int STG_01  = 10,
  parameter int STG_10  = 8,
  parameter int STG_11  = 16,
  parameter int POR_CYC = 4
) (
  input  logic       clk,
  input  logic       pwr_ok,
  input  logic       mrst,
  input  logic       por_skip,
  input  logic [1:0] stage_sel,
  input  logic       free_run,
  input  logic       inv_out,
  output logic       tout
);
  localparam int POR_W = $clog2(POR_CYC + 1);

  logic             started;
  logic [POR_W-1:0] por_cnt;
  logic             por_act;
  logic             any_rst;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             tap;
  logic             hit;
  logic             lvl;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      started <= 1'b0;
      por_cnt <= '0;
    end else begin
      started <= 1'b1;
      if (!started && !por_skip)
        por_cnt <= POR_W'(POR_CYC);
      else if (por_cnt != '0)
        por_cnt <= por_cnt - 1'b1;
    end
  end

  assign por_act = (por_cnt != '0);
  assign any_rst = mrst | por_act;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (any_rst) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed) begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (stage_sel)
      2'b00:   tap = cnt[STG_00-1];
      2'b01:   tap = cnt[STG_01-1];
      2'b10:   tap = cnt[STG_10-1];
      default: tap = cnt[STG_11-1];
    endcase
  end

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok)       hit <= 1'b0;
    else if (any_rst)  hit <= 1'b0;
    else if (free_run) hit <= 1'b0;
    else if (tap)      hit <= 1'b1;
  end

  assign lvl  = free_run ? tap : (hit | tap);
  assign tout = lvl ^ inv_out;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!pwr_ok)
    (armed && !any_rst) |=> cnt == $past(cnt) + 1'b1);

  assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!pwr_ok)
    (!armed && !any_rst) |=> $stable(cnt));

  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!pwr_ok)
    any_rst |=> (cnt == '0 && !hit));

  assert_por_zero_R8: assert property (@(posedge clk) disable iff (!pwr_ok)
    por_act |-> cnt == '0);

  assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!pwr_ok)
    (hit && !free_run && !any_rst) |=> hit);

  assert_follow_R5: assert property (@(posedge clk) disable iff (!pwr_ok)
    free_run |=> !hit);
endmodule

// File: tb/test_tap_timer.sv
module test_tap_timer;
  localparam int PER = 20;
  localparam int POR = 4;

  logic       clk = 1'b0;
  logic       pwr_ok = 1'b0;
  logic       mrst = 1'b0;
  logic       por_skip = 1'b0;
  logic [1:0] stage_sel = 2'b10;
  logic       free_run = 1'b1;
  logic       inv_out = 1'b0;
  logic       tout;

  int errors = 0;
  int checks = 0;

  bit          m_on = 1'b0;
  int unsigned m_cnt = 0;
  bit          m_hit = 1'b0;

  always #(PER/2) clk = ~clk;

  tap_timer i_tap_timer (
    .clk(clk), .pwr_ok(pwr_ok), .mrst(mrst), .por_skip(por_skip),
    .stage_sel(stage_sel), .free_run(free_run), .inv_out(inv_out), .tout(tout)
  );

  // stage map: {B,A} 00->13, 01->10, 10->8, 11->16
  function automatic int stage_of(logic [1:0] s);
    case (s)
      2'b00:   return 13;
      2'b01:   return 10;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic bit_at(int unsigned c, logic [1:0] s);
    return logic'((c >> (stage_of(s) - 1)) & 1);
  endfunction

  function automatic logic exp_out(int unsigned c, logic [1:0] s, logic fr, logic h, logic inv);
    logic t;
    t = bit_at(c, s);
    return (fr ? t : (h | t)) ^ inv;
  endfunction

  always @(posedge clk) begin
    if (m_on) begin
      if (mrst) begin
        m_cnt = 0;
        m_hit = 1'b0;
      end else begin
        if (free_run) m_hit = 1'b0;
        else if (bit_at(m_cnt, stage_sel)) m_hit = 1'b1;
        m_cnt = (m_cnt + 1) & 32'hFFFF;
      end
    end
  end

  task automatic check(string req, logic exp);
    checks++;
    if (tout !== exp) begin
      errors++;
      $display("FAIL %s: tout=%b expected %b (t=%0t)", req, tout, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      if (m_on) check(free_run ? "R3" : "R4", exp_out(m_cnt, stage_sel, free_run, m_hit, inv_out));
    end
  endtask

  task automatic pulse_reset();
    mrst = 1'b1;
    cyc(1);
    mrst = 1'b0;
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R10", 1'b0);
    inv_out = 1'b1; #1;
    check("R6", 1'b1);
    inv_out = 1'b0;

    // R8: power-on pulse, stage 8 divider rises on edge 128+POR+1
    @(negedge clk);
    pwr_ok = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", 1'b0);
    repeat (128 + POR - 3) @(negedge clk);
    check("R8", 1'b0);
    @(negedge clk);
    check("R8", 1'b1);

    // R9: skipped power-on pulse leaves the counter idle
    pwr_ok = 1'b0;
    por_skip = 1'b1;
    @(negedge clk);
    check("R10", 1'b0);
    pwr_ok = 1'b1;
    repeat (300) begin
      @(negedge clk);
      check("R9", 1'b0);
    end
    m_on = 1'b1;
    pulse_reset();
    cyc(127);
    check("R9", 1'b0);
    cyc(1);
    check("R9", 1'b1);

    // R2: tap mapping
    for (int s = 0; s < 3; s++) begin
      stage_sel = 2'(s);
      free_run = 1'b1;
      pulse_reset();
      cyc((1 << (stage_of(2'(s)) - 1)) - 1);
      check("R2", 1'b0);
      cyc(1);
      check("R2", 1'b1);
    end

    // R7: held master reset
    mrst = 1'b1;
    repeat (5) begin
      cyc(1);
      check("R7", inv_out);
    end
    mrst = 1'b0;

    // random phase
    void'($urandom(32'd4541));
    for (int i = 0; i < 6000; i++) begin
      cyc(1);
      if ($urandom % 64 == 0) stage_sel = 2'($urandom % 3);
      if ($urandom % 32 == 0) free_run = ~free_run;
      if ($urandom % 16 == 0) inv_out = ~inv_out;
      if (mrst) begin
        if ($urandom % 2 == 0) mrst = 1'b0;
      end else if ($urandom % 300 == 0) mrst = 1'b1;
    end
    mrst = 1'b0;
    inv_out = 1'b0;

    // R4 and R1: stage 16 one-shot, held across the counter wrap
    stage_sel = 2'b11;
    free_run = 1'b0;
    pulse_reset();
    cyc(32767);
    check("R4", 1'b0);
    cyc(1);
    check("R4", 1'b1);
    cyc(33000);
    check("R1", 1'b1);
    free_run = 1'b1; #1;
    check("R5", 1'b0);
    cyc(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule